// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and End-of-Interrupt Unit

This block is the last stage of an interrupt controller and serves one processor. It keeps two bit vectors indexed by source number. The raised set holds interrupts that were delivered but not yet taken. The servicing set holds interrupts the processor has taken but not yet retired. The block also holds a 4-bit current task priority and drives the processor's interrupt request line. The routing stage sends a delivery strobe carrying a source index. The block takes each source's priority, vector and sense type from a lookup bus. It keeps a per-source activity bit of its own, and the source stage can clear that bit when a level-sensitive input drops.

The processor acknowledges by pulsing `ack_i`. One cycle later the block returns either the vector of the best raised interrupt or the programmed spurious vector. When the processor has finished handling an interrupt it pulses `eoi_i`. That retires the highest-priority servicing entry and can raise the request line again for a waiting interrupt. Nested handling follows from the two sets. A delivery whose priority is below that of an interrupt already in service does not raise the line, and it waits until the end-of-interrupt for that higher interrupt.

Top module: `cpu_intack_unit`

## Requirements
- R1: After reset both sets are empty, all activity bits are clear, `irq_o` is low, the task priority is 15 and the spurious vector is 0xFF.
- R2: A delivery whose source priority is less than or equal to the task priority changes nothing.
- R3: A delivery of a source already in the raised set is a miss and changes nothing.
- R4: Any other delivery sets the source's activity bit and adds it to the raised set. `irq_o` is asserted when the new priority is not below the best raised priority and not below the best servicing priority; otherwise `irq_o` keeps its value.
- R5: The best entry of a set is the one with the highest priority. When priorities are equal, the lowest source index wins.
- R6: An acknowledge drives `irq_o` low. With an empty raised set it returns the spurious vector, which is written with `spur_wr_i`/`spur_data_i`.
- R7: On acknowledge, if the best raised source has its activity bit clear, or its priority no longer exceeds the task priority, its activity bit clears and the spurious vector is returned. Otherwise the source joins the servicing set and its vector is returned.
- R8: On acknowledge the selected source always leaves the raised set. Its activity bit also clears when it is edge-sensitive (`src_level_i` bit = 0). It stays set when the source is level-sensitive (bit = 1).
- R9: An end-of-interrupt removes the best servicing entry. It then asserts `irq_o` if the raised set is non-empty and its best priority exceeds the best priority left in servicing, or if servicing is now empty.
- R10: An end-of-interrupt while the servicing set is empty has no effect.
- R11: A bit set in `lvl_drop_i` clears that source's activity bit.
- R12: The acknowledge result appears on `ack_vec_o` with `ack_valid_o` high in the cycle after `ack_i`. `ack_valid_o` is low in every other cycle.
- R13: At most one of delivery, acknowledge, end-of-interrupt, activity drop, task-priority write and spurious-vector write may occur in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid_i | input | 1 | Delivery strobe from the routing stage |
| dlv_src_i | input | IDX_W | Source index of the delivery |
| src_prio_i | input | NUM_SRC*PRIO_W | Priority of each source, source i at bits [i*PRIO_W +: PRIO_W] |
| src_vec_i | input | NUM_SRC*VEC_W | Vector of each source, source i at bits [i*VEC_W +: VEC_W] |
| src_level_i | input | NUM_SRC | Sense type per source, 1 = level, 0 = edge |
| lvl_drop_i | input | NUM_SRC | Clears the activity bit of each source whose bit is set |
| tp_wr_i | input | 1 | Task priority write strobe |
| tp_data_i | input | PRIO_W | New task priority |
| spur_wr_i | input | 1 | Spurious vector write strobe |
| spur_data_i | input | VEC_W | New spurious vector |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| ack_vec_o | output | VEC_W | Vector returned by the last acknowledge |
| ack_valid_o | output | 1 | High for one cycle while `ack_vec_o` holds a new result |
| irq_o | output | 1 | Interrupt request to the processor |
| active_o | output | NUM_SRC | Activity bit per source |

## Verification
The hardest state to reach is an acknowledge that finds a raised entry which is no longer valid. To get there, the source must be delivered first. Then, before the acknowledge, the task priority must be raised to or above the source's priority, or the source's priority must be lowered on the lookup bus, or its activity must be dropped. The random stream mixes task-priority writes, priority changes on the lookup bus and activity drops between deliveries and acknowledges, so all three paths occur many times. Directed sequences before the random phase cover the reset state, ties between equal priorities, nested servicing where a lower delivery is held back until the end-of-interrupt, and an end-of-interrupt with nothing in service.

// File: rtl/cpu_intack_unit.sv
module cpu_intack_unit #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int PICK_W = 1 + IDX_W + PRIO_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dlv_valid_i,
  input  logic [IDX_W-1:0]           dlv_src_i,
  input  logic [NUM_SRC*PRIO_W-1:0]  src_prio_i,
  input  logic [NUM_SRC*VEC_W-1:0]   src_vec_i,
  input  logic [NUM_SRC-1:0]         src_level_i,
  input  logic [NUM_SRC-1:0]         lvl_drop_i,
  input  logic                       tp_wr_i,
  input  logic [PRIO_W-1:0]          tp_data_i,
  input  logic                       spur_wr_i,
  input  logic [VEC_W-1:0]           spur_data_i,
  input  logic                       ack_i,
  input  logic                       eoi_i,
  output logic [VEC_W-1:0]           ack_vec_o,
  output logic                       ack_valid_o,
  output logic                       irq_o,
  output logic [NUM_SRC-1:0]         active_o
);

  logic [NUM_SRC-1:0] raised_q, serv_q, act_q;
  logic [PRIO_W-1:0]  tp_q;
  logic [VEC_W-1:0]   spur_q, ack_vec_q;
  logic               irq_q, ack_valid_q;

  // best entry of a mask: {found, index, priority}; ties keep the lower index
  function automatic logic [PICK_W-1:0] pick(input logic [NUM_SRC-1:0] m,
                                             input logic [NUM_SRC*PRIO_W-1:0] pv);
    logic              f;
    logic [IDX_W-1:0]  ix;
    logic [PRIO_W-1:0] bp;
    f = 1'b0; ix = '0; bp = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (m[i] && (!f || pv[i*PRIO_W +: PRIO_W] > bp)) begin
        f  = 1'b1;
        ix = IDX_W'(i);
        bp = pv[i*PRIO_W +: PRIO_W];
      end
    end
    return {f, ix, bp};
  endfunction

  logic              r_f, s_f, s2_f;
  logic [IDX_W-1:0]  r_ix, s_ix, s2_ix;
  logic [PRIO_W-1:0] r_pr, s_pr, s2_pr;
  logic [NUM_SRC-1:0] s_one;

  assign {r_f, r_ix, r_pr} = pick(raised_q, src_prio_i);
  assign {s_f, s_ix, s_pr} = pick(serv_q, src_prio_i);
  assign s_one = NUM_SRC'(1) << s_ix;
  assign {s2_f, s2_ix, s2_pr} = pick(serv_q & ~s_one, src_prio_i);

  logic [PRIO_W-1:0] dlv_pr;
  logic              dlv_take, dlv_raise;
  assign dlv_pr    = src_prio_i[dlv_src_i*PRIO_W +: PRIO_W];
  assign dlv_take  = dlv_valid_i && (dlv_pr > tp_q) && !raised_q[dlv_src_i];
  assign dlv_raise = dlv_take && !(r_f && dlv_pr < r_pr) && !(s_f && dlv_pr < s_pr);

  logic ack_good;
  assign ack_good = r_f && act_q[r_ix] && (r_pr > tp_q);

  logic eoi_reraise;
  assign eoi_reraise = r_f && (!s2_f || r_pr > s2_pr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raised_q    <= '0;
      serv_q      <= '0;
      act_q       <= '0;
      tp_q        <= '1;
      spur_q      <= '1;
      ack_vec_q   <= '0;
      ack_valid_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      ack_valid_q <= ack_i;
      if (tp_wr_i) tp_q <= tp_data_i;
      if (spur_wr_i) spur_q <= spur_data_i;
      if (|lvl_drop_i) act_q <= act_q & ~lvl_drop_i;
      if (dlv_take) begin
        act_q[dlv_src_i]    <= 1'b1;
        raised_q[dlv_src_i] <= 1'b1;
        if (dlv_raise) irq_q <= 1'b1;
      end
      if (ack_i) begin
        irq_q <= 1'b0;
        if (!r_f) begin
          ack_vec_q <= spur_q;
        end else begin
          raised_q[r_ix] <= 1'b0;
          if (ack_good) begin
            serv_q[r_ix] <= 1'b1;
            ack_vec_q    <= src_vec_i[r_ix*VEC_W +: VEC_W];
            if (!src_level_i[r_ix]) act_q[r_ix] <= 1'b0;
          end else begin
            act_q[r_ix] <= 1'b0;
            ack_vec_q   <= spur_q;
          end
        end
      end
      if (eoi_i && s_f) begin
        serv_q[s_ix] <= 1'b0;
        if (eoi_reraise) irq_q <= 1'b1;
      end
    end
  end

  assign ack_vec_o   = ack_vec_q;
  assign ack_valid_o = ack_valid_q;
  assign irq_o       = irq_q;
  assign active_o    = act_q;

  // R13
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dlv_valid_i, ack_i, eoi_i, |lvl_drop_i, tp_wr_i, spur_wr_i}) <= 1);

  // R6
  ack_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !irq_o);

  // R12
  ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ack_valid_o);

  // R12
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !ack_valid_o);

  // R2
  low_prio_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_i && dlv_pr <= tp_q) |=> ($stable(raised_q) && $stable(irq_o)));

  // R3
  missed_dlv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid_i && raised_q[dlv_src_i]) |=> ($stable(raised_q) && $stable(irq_o)));

  // R10
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && serv_q == '0) |=> ($stable(serv_q) && $stable(irq_o)));

  // R8
  ack_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && raised_q != '0) |=> ($countones(raised_q) + 1 == $countones($past(raised_q))));

endmodule

// File: tb/cpu_intack_unit_tb_top.sv
module cpu_intack_unit_tb_top;
  localparam int N  = 16;
  localparam int PW = 4;
  localparam int VW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          dlv_valid_i = 0;
  logic [IW-1:0] dlv_src_i = '0;
  logic [N*PW-1:0] src_prio_i = '0;
  logic [N*VW-1:0] src_vec_i = '0;
  logic [N-1:0]  src_level_i = '0;
  logic [N-1:0]  lvl_drop_i = '0;
  logic          tp_wr_i = 0;
  logic [PW-1:0] tp_data_i = '0;
  logic          spur_wr_i = 0;
  logic [VW-1:0] spur_data_i = '0;
  logic          ack_i = 0, eoi_i = 0;
  logic [VW-1:0] ack_vec_o;
  logic          ack_valid_o, irq_o;
  logic [N-1:0]  active_o;

  cpu_intack_unit #(.NUM_SRC(N), .PRIO_W(PW), .VEC_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dlv_valid_i(dlv_valid_i), .dlv_src_i(dlv_src_i),
    .src_prio_i(src_prio_i), .src_vec_i(src_vec_i), .src_level_i(src_level_i),
    .lvl_drop_i(lvl_drop_i), .tp_wr_i(tp_wr_i), .tp_data_i(tp_data_i),
    .spur_wr_i(spur_wr_i), .spur_data_i(spur_data_i), .ack_i(ack_i), .eoi_i(eoi_i),
    .ack_vec_o(ack_vec_o), .ack_valid_o(ack_valid_o), .irq_o(irq_o), .active_o(active_o));

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_raised, m_serv, m_act;
  logic [PW-1:0] m_tp;
  logic [VW-1:0] m_spur, m_vec;
  logic m_irq;

  function automatic logic [PW-1:0] pr(int i);
    return src_prio_i[i*PW +: PW];
  endfunction

  function automatic int best(logic [N-1:0] m);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (b < 0 || pr(i) > pr(b))) b = i;
    return b;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_cycle(string req, bit was_ack);
    @(negedge clk);
    dlv_valid_i = 0; ack_i = 0; eoi_i = 0; tp_wr_i = 0; spur_wr_i = 0; lvl_drop_i = '0;
    chk(irq_o == m_irq, req, irq_o, m_irq);
    chk(active_o == m_act, req, active_o, m_act);
    chk(ack_valid_o == was_ack, "R12", ack_valid_o, was_ack);
    if (was_ack) chk(ack_vec_o == m_vec, req, ack_vec_o, m_vec);
  endtask

  task automatic do_dlv(int s);
    string req;
    int rb, sb;
    req = "R4";
    rb = best(m_raised); sb = best(m_serv);
    if (pr(s) <= m_tp) req = "R2";
    else if (m_raised[s]) req = "R3";
    else begin
      m_act[s] = 1; m_raised[s] = 1;
      if (!(rb >= 0 && pr(s) < pr(rb)) && !(sb >= 0 && pr(s) < pr(sb))) m_irq = 1;
    end
    dlv_src_i = IW'(s); dlv_valid_i = 1;
    finish_cycle(req, 0);
  endtask

  task automatic do_ack();
    int r;
    string req;
    r = best(m_raised);
    m_irq = 0;
    req = "R6";
    if (r < 0) m_vec = m_spur;
    else begin
      m_raised[r] = 0;
      if (m_act[r] && pr(r) > m_tp) begin
        req = "R8";
        m_serv[r] = 1; m_vec = src_vec_i[r*VW +: VW];
        if (!src_level_i[r]) m_act[r] = 0;
      end else begin
        req = "R7";
        m_act[r] = 0; m_vec = m_spur;
      end
    end
    ack_i = 1;
    finish_cycle(req, 1);
  endtask

  task automatic do_eoi();
    int s, r, s2;
    logic [N-1:0] rest;
    string req;
    s = best(m_serv);
    req = "R10";
    if (s >= 0) begin
      req = "R9";
      m_serv[s] = 0;
      rest = m_serv;
      s2 = best(rest); r = best(m_raised);
      if (r >= 0 && (s2 < 0 || pr(r) > pr(s2))) m_irq = 1;
    end
    eoi_i = 1;
    finish_cycle(req, 0);
  endtask

  task automatic do_tp(int v);
    m_tp = PW'(v); tp_data_i = PW'(v); tp_wr_i = 1;
    finish_cycle("R4", 0);
  endtask

  task automatic do_spur(int v);
    m_spur = VW'(v); spur_data_i = VW'(v); spur_wr_i = 1;
    finish_cycle("R6", 0);
  endtask

  task automatic do_drop(logic [N-1:0] m);
    m_act = m_act & ~m; lvl_drop_i = m;
    finish_cycle("R11", 0);
  endtask

  task automatic set_prio(int s, int p);
    @(negedge clk);
    src_prio_i[s*PW +: PW] = PW'(p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed, k;
    seed = 17;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) begin
      src_vec_i[i*VW +: VW] = VW'(8'h40 + i);
      src_prio_i[i*PW +: PW] = PW'(1 + ($urandom % 15));
    end
    src_level_i = 16'h00F0;
    m_raised = '0; m_serv = '0; m_act = '0; m_tp = 15; m_spur = 8'hFF; m_irq = 0; m_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq_o == 0, "R1", irq_o, 0);
    chk(active_o == '0, "R1", active_o, 0);
    set_prio(2, 15);
    do_dlv(2);              // R1 task priority 15 drops even priority 15
    do_ack();               // R1 spurious 0xFF
    do_tp(0);
    // R5 tie: sources 3 and 5 at equal priority, lower index first
    set_prio(3, 7); set_prio(5, 7); set_prio(9, 9); set_prio(1, 2);
    do_dlv(5); do_dlv(3);
    do_dlv(3);              // R3 miss
    do_ack();
    chk(ack_vec_o == 8'h43, "R5", ack_vec_o, 8'h43);
    // nested: priority 9 while 7 in service
    do_dlv(9);
    do_ack();
    do_dlv(1);              // R4 below servicing: no request
    do_eoi();               // R9 retires 9, raised best 7 > 7? no
    do_ack();
    chk(ack_vec_o == 8'h45, "R5", ack_vec_o, 8'h45);
    do_eoi(); do_eoi();     // R9 then last one re-raises for source 1
    do_eoi(); do_eoi();     // R10 empty
    do_spur(8'h3C);
    do_tp(5);
    do_ack();               // R7 source 1 prio 2 <= 5: spurious 0x3C
    chk(ack_vec_o == 8'h3C, "R7", ack_vec_o, 8'h3C);
    // R11 then R7 on a dropped level source
    set_prio(4, 12);
    do_dlv(4);
    do_drop(16'h0010);
    do_ack();
    chk(ack_vec_o == 8'h3C, "R11", ack_vec_o, 8'h3C);
    do_tp(1);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      k = $urandom % 100;
      if (k < 40) do_dlv($urandom % N);
      else if (k < 60) do_ack();
      else if (k < 75) do_eoi();
      else if (k < 80) do_tp($urandom % 9);
      else if (k < 85) do_drop(N'($urandom) & N'($urandom) & N'($urandom));
      else if (k < 92) set_prio($urandom % N, $urandom % 16);
      else if (k < 94) do_spur($urandom % 256);
      else finish_cycle("R12", 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule